// File: doc/BRIEF.md
# Composite Clock Root Slice

This block derives one output clock from a bank of eight source clocks. A single 32-bit control word, written through a plain strobe-and-data port on a configuration clock, chooses the source, programs two cascaded integer dividers and opens or closes an output gate. The selected source first passes through a pre-divider with ratios 1 to 8, whose output then clocks a post-divider with ratios 1 to 64. The result is ANDed with the enable bit.

Both divider fields hold the ratio minus one, so a field of zero means divide by one, and in that case the stage passes its input clock straight through. Odd ratios give a high phase one input cycle longer than the low phase, and even ratios give a 50% duty cycle. A newly written ratio is adopted by a stage only at that stage's terminal count, so a divider change never cuts a period short. The control word reads back at any time. Bits that belong to no field read as zero.

Top module: `clk_root_slice`

## Requirements
- R1: After reset the control word reads back as zero. The output is therefore gated off and low, both ratios are one, and source 0 is selected.
- R2: Field layout: the enable is bit 28, the source select is bits 26:24, the pre-divider field (ratio minus one) is bits 18:16, and the post-divider field (ratio minus one) is bits 5:0. A write stores these fields, and the readback in the following configuration cycle returns them. All other bits are ignored on write and read as zero. Without a write, the readback holds its value.
- R3: While the enable bit is clear, the output is held low.
- R4: The source select picks which of the eight source clocks drives the divider chain. The index reads back from bits 26:24.
- R5: The output period equals the selected source period times the pre ratio times the post ratio.
- R6: A ratio of one at a stage passes that stage's input clock through unchanged. With both ratios at one, the output follows the source waveform, including its duty cycle.
- R7: For a stage with a ratio N above one, the stage output is high for ceil(N/2) of its input cycles and low for floor(N/2) of its input cycles.
- R8: A write that changes only the select field leaves the divider fields and the enable bit as they were. A write that changes only the divider fields leaves the select and enable as they were. The output follows the new setting.
- R9: Each divider stage keeps its active ratio until its own terminal count, and loads a newly written field only at that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Configuration clock for the control word |
| rst_n | input | 1 | Active-low asynchronous reset for all stages |
| src_clk | input | 8 | Source clocks, one bit per source |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word readback |
| clk_out | output | 1 | Gated, divided output clock |

## Verification
The assertions assume that the source clocks keep toggling, so that each divider stage reaches its terminal count and the hold-until-terminal-count properties describe real edges. They also assume that the control word does not change in the same instant as a divider edge samples it. The stimulus meets both assumptions. Every source runs freely from time zero with a fixed period. Writes are driven on the falling configuration edge, and each output measurement starts only after a settling time of two old and two new output periods, so any pending ratio has been loaded before an edge is timed.

// File: rtl/clk_root_slice_pkg.sv
package clk_root_slice_pkg;

  localparam int WORD_W   = 32;
  localparam int GATE_BIT = 28;
  localparam int SRC_LSB  = 24;
  localparam int SRC_W    = 3;
  localparam int PRE_LSB  = 16;
  localparam int PRE_W    = 3;
  localparam int POST_LSB = 0;
  localparam int POST_W   = 6;
  localparam int NUM_SRC  = 1 << SRC_W;

  typedef struct packed {
    logic              gate;
    logic [SRC_W-1:0]  src;
    logic [PRE_W-1:0]  pre;
    logic [POST_W-1:0] post;
  } ctrl_t;

  // Decode a raw word into fields; unused bits drop out here.
  function automatic ctrl_t word_to_ctrl(input logic [WORD_W-1:0] w);
    ctrl_t c;
    c.gate = w[GATE_BIT];
    c.src  = w[SRC_LSB  +: SRC_W];
    c.pre  = w[PRE_LSB  +: PRE_W];
    c.post = w[POST_LSB +: POST_W];
    return c;
  endfunction

  // Pack fields back into the word layout; everything else is zero.
  function automatic logic [WORD_W-1:0] ctrl_to_word(input ctrl_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[GATE_BIT]             = c.gate;
    w[SRC_LSB  +: SRC_W]    = c.src;
    w[PRE_LSB  +: PRE_W]    = c.pre;
    w[POST_LSB +: POST_W]   = c.post;
    return w;
  endfunction

  // Bits that hold state in the control word.
  function automatic logic [WORD_W-1:0] live_mask();
    ctrl_t c;
    c.gate = 1'b1;
    c.src  = '1;
    c.pre  = '1;
    c.post = '1;
    return ctrl_to_word(c);
  endfunction

endpackage

// File: rtl/clk_root_slice_ctrl.sv
module clk_root_slice_ctrl
  import clk_root_slice_pkg::*;
(
  input  logic              cfg_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output ctrl_t             ctrl,
  output logic [WORD_W-1:0] rd_data
);

  ctrl_t ctrl_q;

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= word_to_ctrl(wr_data);
    end
  end

  assign ctrl    = ctrl_q;
  assign rd_data = ctrl_to_word(ctrl_q);

endmodule

// File: rtl/clk_root_slice_mux.sv
module clk_root_slice_mux #(
  parameter int N_SRC = 8,
  parameter int SEL_W = 3
) (
  input  logic [N_SRC-1:0] src_clk,
  input  logic [SEL_W-1:0] sel,
  output logic             clk_o
);

  logic [N_SRC-1:0] pick;

  for (genvar i = 0; i < N_SRC; i++) begin : g_leg
    assign pick[i] = src_clk[i] & (sel == SEL_W'(i));
  end

  assign clk_o = |pick;

endmodule

// File: rtl/clk_root_slice_div.sv
module clk_root_slice_div #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_n,
  input  logic [W-1:0] ratio_m1,
  output logic         clk_o,
  output logic         tc_o,
  output logic [W-1:0] act_o
);

  localparam int CW = W + 1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] act_q;
  logic         phase_q;
  logic [CW-1:0] cnt_nxt;

  // Number of input cycles the stage output stays high: ceil(N/2).
  function automatic logic [CW-1:0] high_len(input logic [W-1:0] a);
    return CW'((CW'(a) + CW'(2)) >> 1);
  endfunction

  assign tc_o    = (cnt_q == act_q);
  assign cnt_nxt = CW'(cnt_q) + CW'(1);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      act_q   <= '0;
      phase_q <= 1'b0;
    end else if (tc_o) begin
      act_q   <= ratio_m1;
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_nxt[W-1:0];
      phase_q <= (cnt_nxt < high_len(act_q));
    end
  end

  assign clk_o = (act_q == '0) ? clk_i : phase_q;
  assign act_o = act_q;

endmodule

// File: rtl/clk_root_slice.sv
module clk_root_slice
  import clk_root_slice_pkg::*;
(
  input  logic               cfg_clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic               wr_en,
  input  logic [WORD_W-1:0]  wr_data,
  output logic [WORD_W-1:0]  rd_data,
  output logic               clk_out
);

  ctrl_t              ctrl;
  logic               sel_clk;
  logic               pre_clk;
  logic               post_clk;
  logic               pre_tc;
  logic               post_tc;
  logic [PRE_W-1:0]   pre_act;
  logic [POST_W-1:0]  post_act;

  clk_root_slice_ctrl u_ctrl (
    .cfg_clk (cfg_clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl    (ctrl),
    .rd_data (rd_data)
  );

  clk_root_slice_mux #(.N_SRC(NUM_SRC), .SEL_W(SRC_W)) u_mux (
    .src_clk (src_clk),
    .sel     (ctrl.src),
    .clk_o   (sel_clk)
  );

  clk_root_slice_div #(.W(PRE_W)) u_pre (
    .clk_i    (sel_clk),
    .rst_n    (rst_n),
    .ratio_m1 (ctrl.pre),
    .clk_o    (pre_clk),
    .tc_o     (pre_tc),
    .act_o    (pre_act)
  );

  clk_root_slice_div #(.W(POST_W)) u_post (
    .clk_i    (pre_clk),
    .rst_n    (rst_n),
    .ratio_m1 (ctrl.post),
    .clk_o    (post_clk),
    .tc_o     (post_tc),
    .act_o    (post_act)
  );

  assign clk_out = ctrl.gate & post_clk;

endmodule

// File: rtl/clk_root_slice_chk.sv
module clk_root_slice_chk
  import clk_root_slice_pkg::*;
(
  input logic               cfg_clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [WORD_W-1:0]  wr_data,
  input logic [WORD_W-1:0]  rd_data,
  input logic               clk_out,
  input logic               sel_clk,
  input logic               pre_clk,
  input logic               pre_tc,
  input logic               post_tc,
  input logic [PRE_W-1:0]   pre_act,
  input logic [POST_W-1:0]  post_act
);

  // R2: a write is visible, masked, in the next readback
  a_r2_write_readback: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    wr_en |=> (rd_data == ($past(wr_data) & live_mask())));

  // R2: without a write the readback does not move
  a_r2_hold: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

  // R3: gate bit clear keeps the output low
  a_r3_gate_low: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !rd_data[GATE_BIT] |-> !clk_out);

  // R9: pre stage ratio changes only after its terminal count
  a_r9_pre_hold: assert property (@(posedge sel_clk) disable iff (!rst_n)
    !pre_tc |=> $stable(pre_act));

  // R9: post stage ratio changes only after its terminal count
  a_r9_post_hold: assert property (@(posedge pre_clk) disable iff (!rst_n)
    !post_tc |=> $stable(post_act));

endmodule

bind clk_root_slice clk_root_slice_chk u_chk (
  .cfg_clk  (cfg_clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .clk_out  (clk_out),
  .sel_clk  (sel_clk),
  .pre_clk  (pre_clk),
  .pre_tc   (pre_tc),
  .post_tc  (post_tc),
  .pre_act  (pre_act),
  .post_act (post_act)
);

// File: tb/clk_root_slice_tb.sv
`timescale 1ns/1ps
module clk_root_slice_tb;

  logic        cfg_clk = 1'b0;
  logic        rst_n   = 1'b0;
  logic [7:0]  src_clk = '0;
  logic        wr_en   = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        clk_out;

  int n_chk  = 0;
  int n_fail = 0;
  int prev_per = 10;

  clk_root_slice u_dut (
    .cfg_clk (cfg_clk),
    .rst_n   (rst_n),
    .src_clk (src_clk),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .clk_out (clk_out)
  );

  always #10 cfg_clk = ~cfg_clk;

  // Source i has period 10 + 4*i ns.
  for (genvar i = 0; i < 8; i++) begin : g_src
    initial forever #(5 + 2*i) src_clk[i] = ~src_clk[i];
  end

  function automatic int src_per(input int i);
    return 10 + 4*i;
  endfunction

  function automatic logic [31:0] mk_word(input bit en, input int sel,
                                          input int pre_r, input int post_r);
    logic [31:0] w;
    w = 32'h0;
    w[28]    = en;
    w[26:24] = 3'(sel);
    w[18:16] = 3'(pre_r - 1);
    w[5:0]   = 6'(post_r - 1);
    return w;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge cfg_clk);
    wr_en   = 1'b1;
    wr_data = w;
    @(negedge cfg_clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  // Measure period and high time of clk_out against the expected ratios.
  task automatic measure(input string req, input int sel, input int pre_r, input int post_r);
    int p, per, hi;
    realtime t0, t1, t2;
    p   = src_per(sel);
    per = p * pre_r * post_r;
    if (post_r > 1)     hi = ((post_r + 1) / 2) * pre_r * p;
    else if (pre_r > 1) hi = ((pre_r + 1) / 2) * p;
    else                hi = p / 2;
    #(2*prev_per + 2*per + 100);
    @(posedge clk_out); t0 = $realtime;
    @(negedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    check(req, "period", $rtoi(t2 - t0), per);
    check(req, "high",   $rtoi(t1 - t0), hi);
    prev_per = per;
  endtask

  task automatic t_reset;
    check("R1", "readback", rd_data, 0);
    check("R1", "clk_out",  int'(clk_out), 0);
  endtask

  task automatic t_passthrough;
    write_word(mk_word(1, 0, 1, 1));
    check("R2", "readback", rd_data, 32'h1000_0000);
    measure("R6", 0, 1, 1);
    write_word(mk_word(1, 5, 1, 1));
    measure("R6", 5, 1, 1);
  endtask

  task automatic t_pre_only;
    write_word(mk_word(1, 2, 4, 1));
    measure("R5", 2, 4, 1);
    write_word(mk_word(1, 1, 3, 1));
    measure("R7", 1, 3, 1);
  endtask

  task automatic t_post_only;
    write_word(mk_word(1, 3, 1, 5));
    measure("R7", 3, 1, 5);
    write_word(mk_word(1, 4, 1, 2));
    measure("R5", 4, 1, 2);
  endtask

  task automatic t_cascade;
    write_word(mk_word(1, 7, 3, 3));
    measure("R5", 7, 3, 3);
    write_word(mk_word(1, 0, 8, 64));
    check("R2", "readback", rd_data, 32'h1007_003F);
    measure("R9", 0, 8, 64);
  endtask

  task automatic t_independence;
    write_word(mk_word(1, 2, 2, 6));
    measure("R8", 2, 2, 6);
    write_word(mk_word(1, 6, 2, 6));
    check("R8", "pre field kept",  int'(rd_data[18:16]), 1);
    check("R8", "post field kept", int'(rd_data[5:0]), 5);
    check("R8", "enable kept",     int'(rd_data[28]), 1);
    measure("R8", 6, 2, 6);
    write_word(mk_word(1, 6, 5, 3));
    check("R8", "select kept", int'(rd_data[26:24]), 6);
    check("R8", "enable kept", int'(rd_data[28]), 1);
    measure("R8", 6, 5, 3);
  endtask

  task automatic t_reserved;
    write_word(32'hFFFF_FFFF);
    check("R2", "reserved masked", rd_data, 32'h1707_003F);
    measure("R2", 7, 8, 64);
  endtask

  task automatic t_all_sources;
    for (int s = 0; s < 8; s++) begin
      write_word(mk_word(1, s, 2, 1));
      check("R4", "select readback", int'(rd_data[26:24]), s);
      measure("R4", s, 2, 1);
    end
  endtask

  task automatic t_gate;
    int highs;
    write_word(mk_word(0, 0, 1, 1));
    check("R3", "enable readback", int'(rd_data[28]), 0);
    highs = 0;
    for (int k = 0; k < 300; k++) begin
      #7;
      if (clk_out !== 1'b0) highs++;
    end
    check("R3", "high samples while gated", highs, 0);
    write_word(mk_word(1, 0, 1, 2));
    measure("R3", 0, 1, 2);
  endtask

  initial begin : watchdog
    #3_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge cfg_clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge cfg_clk);
    t_reset();
    t_passthrough();
    t_pre_only();
    t_post_only();
    t_cascade();
    t_independence();
    t_reserved();
    t_all_sources();
    t_gate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule